// File: doc/BRIEF.md
# Master-Mode Sensor Readout Timing Generator

This block produces the readout framing of a CMOS image sensor whose readout is timed from inside the chip. From a single clock it counts lead-in cycles, row slots and column positions. From those counts it drives a frame envelope, a per-row envelope, an integration indicator and a pixel strobe with a predictable 10-bit synthetic sample. A start pulse launches free-running operation. From then on, frames follow one another with no gap until reset.

Each frame opens with a short lead-in during which only the frame envelope is high. After that come row slots of fixed length. Each slot has a delay cycle, then the active columns, then a few idle cycles. The frame holds as many row slots as the larger of the sensor height and the programmed exposure length, counted in rows. An exposure longer than the readout therefore stretches the frame instead of cutting integration short. The exposure length is captured only when a frame begins, so each frame runs with one consistent value.

Top module: `sensor_readout_timer`

## Requirements
- R1: While rst_n is low, frame_valid, row_valid, expose, pix_stb and pix_data are all 0. After release the block stays idle with all outputs 0 until start is sampled high.
- R2: When start is sampled high on a rising edge while the block is idle, frame_valid is 1 in the cycle that follows. A start pulse while frames are running does not change the timing of any output.
- R3: A frame begins with LEAD (default 2) lead-in cycles. Each row slot lasts DLY+COLS+IDLE cycles (default 1+666+4 = 671): one delay cycle with row_valid low, then COLS cycles with row_valid high, then IDLE cycles with row_valid low. row_valid therefore first rises 3 cycles after frame_valid rises.
- R4: A frame carries ROWS (default 502) active rows. frame_valid falls in the same cycle as row_valid at the end of the last active row. The next frame_valid rise comes exactly LEAD + max(ROWS, exposure)·(DLY+COLS+IDLE) cycles after the previous one.
- R5: When the exposure (in rows) exceeds ROWS, the extra row slots follow the last active row. During those slots frame_valid and row_valid stay low, so the frame period follows the exposure.
- R6: expose is high exactly during row slots 0 to exposure−1 of each frame. It is low during the lead-in, and it is never high when the exposure is 0.
- R7: exp_rows is sampled only when a frame begins, which is either a start from idle or the end of the last row slot. A change at any other time first takes effect in the next frame.
- R8: pix_stb equals row_valid. While it is high, pix_data = (row·32 + column) mod 1024, with row and column counted from 0 in the active area. pix_data is 0 otherwise. Each sample is held for the whole cycle, so that it can be captured on the falling clock edge.
- R9: row_valid is never high while frame_valid is low, and frame_valid never rises while row_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches free-running readout from idle |
| exp_rows | input | EXP_W | Exposure length in row slots, sampled when each frame begins |
| frame_valid | output | 1 | Frame envelope |
| row_valid | output | 1 | Row envelope over the active columns |
| expose | output | 1 | Integration in progress |
| pix_stb | output | 1 | Pixel sample present |
| pix_data | output | DW | Synthetic pixel value |

## Verification
All outputs are decoded from registered counters. A start sampled on a rising edge therefore shows frame_valid in the cycle after that edge (cycle 0). row_valid and the first sample follow in cycle 3, and the next frame begins LEAD + max(ROWS, exposure)·rowlen cycles after cycle 0. The bench takes the cycle after the start edge as cycle 0, counts rising edges from it, and samples every expected value at the falling edge of the computed cycle. That falling edge is also the point where the sample is meant to be captured. A new exposure value is expected to act only from the first cycle of the next frame, and the checks placed in the running frame confirm that it has no effect there.

// File: rtl/sro_pkg.sv
package sro_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_ROWS = 2'd2
    } phase_e;
endpackage

// File: rtl/sro_sequencer.sv
module sro_sequencer
    import sro_pkg::*;
#(
    parameter int LEAD  = 2,
    parameter int RC    = 671,
    parameter int ROWS  = 502,
    parameter int EXP_W = 12,
    parameter int RW    = 12,
    parameter int CW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exp_rows,
    output phase_e           phase,
    output logic [RW-1:0]    row,
    output logic [CW-1:0]    col,
    output logic [EXP_W-1:0] expv
);
    localparam int LW = (LEAD > 1) ? $clog2(LEAD) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [LW-1:0]    lead;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
        logic [EXP_W-1:0] expv;
    } seq_t;

    seq_t s_d, s_q;
    logic [RW-1:0] frame_rows;

    always_comb begin
        s_d = s_q;
        frame_rows = (RW'(s_q.expv) > RW'(ROWS)) ? RW'(s_q.expv) : RW'(ROWS);
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph   = PH_LEAD;
                    s_d.lead = '0;
                    s_d.row  = '0;
                    s_d.col  = '0;
                    s_d.expv = exp_rows;
                end
            end
            PH_LEAD: begin
                if (s_q.lead == LW'(LEAD - 1)) begin
                    s_d.ph  = PH_ROWS;
                    s_d.row = '0;
                    s_d.col = '0;
                end else begin
                    s_d.lead = s_q.lead + 1'b1;
                end
            end
            PH_ROWS: begin
                if (s_q.col == CW'(RC - 1)) begin
                    s_d.col = '0;
                    if (s_q.row == frame_rows - 1'b1) begin
                        s_d.ph   = PH_LEAD;
                        s_d.lead = '0;
                        s_d.row  = '0;
                        s_d.expv = exp_rows;
                    end else begin
                        s_d.row = s_q.row + 1'b1;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, lead: '0, row: '0, col: '0, expv: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign row   = s_q.row;
    assign col   = s_q.col;
    assign expv  = s_q.expv;
endmodule

// File: rtl/sro_envelope.sv
module sro_envelope
    import sro_pkg::*;
#(
    parameter int ROWS  = 502,
    parameter int COLS  = 666,
    parameter int DLY   = 1,
    parameter int EXP_W = 12,
    parameter int RW    = 12,
    parameter int CW    = 10
) (
    input  phase_e           phase,
    input  logic [RW-1:0]    row,
    input  logic [CW-1:0]    col,
    input  logic [EXP_W-1:0] expv,
    output logic             fv,
    output logic             rv,
    output logic             expose
);
    logic in_rows;
    logic past_act;

    always_comb begin
        in_rows  = (phase == PH_ROWS) && (row < RW'(ROWS));
        past_act = (col >= CW'(DLY + COLS));
        rv       = in_rows && (col >= CW'(DLY)) && !past_act;
        fv       = (phase == PH_LEAD) ||
                   (in_rows && !((row == RW'(ROWS - 1)) && past_act));
        expose   = (phase == PH_ROWS) && (row < RW'(expv));
    end
endmodule

// File: rtl/sro_pixel.sv
module sro_pixel #(
    parameter int DLY    = 1,
    parameter int ROW_WT = 32,
    parameter int RW     = 12,
    parameter int CW     = 10,
    parameter int DW     = 10
) (
    input  logic          act,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [DW-1:0] data
);
    localparam int SW = RW + CW + 8;

    logic [SW-1:0] wide;

    always_comb begin
        wide = SW'(row) * SW'(ROW_WT) + SW'(col) - SW'(DLY);
        data = act ? wide[DW-1:0] : '0;
    end
endmodule

// File: rtl/sensor_readout_timer.sv
module sensor_readout_timer
    import sro_pkg::*;
#(
    parameter int COLS   = 666,
    parameter int ROWS   = 502,
    parameter int DLY    = 1,
    parameter int IDLE   = 4,
    parameter int LEAD   = 2,
    parameter int EXP_W  = 12,
    parameter int DW     = 10,
    parameter int ROW_WT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exp_rows,
    output logic             frame_valid,
    output logic             row_valid,
    output logic             expose,
    output logic             pix_stb,
    output logic [DW-1:0]    pix_data
);
    localparam int RC  = DLY + COLS + IDLE;
    localparam int CW  = $clog2(RC);
    localparam int RHW = $clog2(ROWS + 1);
    localparam int RW  = (EXP_W > RHW) ? EXP_W : RHW;

    phase_e           phase;
    logic [RW-1:0]    row;
    logic [CW-1:0]    col;
    logic [EXP_W-1:0] expv;
    logic             rv;

    sro_sequencer #(
        .LEAD(LEAD), .RC(RC), .ROWS(ROWS), .EXP_W(EXP_W), .RW(RW), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_rows(exp_rows),
        .phase(phase), .row(row), .col(col), .expv(expv)
    );

    sro_envelope #(
        .ROWS(ROWS), .COLS(COLS), .DLY(DLY), .EXP_W(EXP_W), .RW(RW), .CW(CW)
    ) u_env (
        .phase(phase), .row(row), .col(col), .expv(expv),
        .fv(frame_valid), .rv(rv), .expose(expose)
    );

    sro_pixel #(
        .DLY(DLY), .ROW_WT(ROW_WT), .RW(RW), .CW(CW), .DW(DW)
    ) u_pix (
        .act(rv), .row(row), .col(col), .data(pix_data)
    );

    assign row_valid = rv;
    assign pix_stb   = rv;
endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
    parameter int COLS = 666,
    parameter int DW   = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fv,
    input logic          rv,
    input logic          stb,
    input logic [DW-1:0] data
);
    localparam int RNW = $clog2(COLS + 2);

    logic [RNW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  run_q <= '0;
        else if (rv) run_q <= run_q + 1'b1;
        else         run_q <= '0;
    end

    // R3
    row_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rv) |-> (run_q == RNW'(COLS)));

    // R3
    row_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rv) |-> $past(fv, 3));

    // R9
    rv_inside_fv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rv |-> fv);

    // R9
    fv_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fv) |-> !rv);

    // R8
    data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> (data == '0));
endmodule

bind sensor_readout_timer sro_checker #(.COLS(COLS), .DW(DW)) u_sro_chk (
    .clk(clk), .rst_n(rst_n), .fv(frame_valid), .rv(row_valid),
    .stb(pix_stb), .data(pix_data)
);

// File: tb/tb_sensor_readout_timer.sv
module tb_sensor_readout_timer;
    localparam int CLK_P = 10;
    localparam int COLS  = 6;
    localparam int ROWS  = 3;
    localparam int IDLE  = 4;
    localparam int EXP_W = 12;
    localparam int DW    = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [EXP_W-1:0] exp_rows = '0;
    logic             frame_valid, row_valid, expose, pix_stb;
    logic [DW-1:0]    pix_data;

    int nchk = 0;
    int nerr = 0;
    int tnow = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sensor_readout_timer #(
        .COLS(COLS), .ROWS(ROWS), .DLY(1), .IDLE(IDLE), .LEAD(2),
        .EXP_W(EXP_W), .DW(DW), .ROW_WT(32)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_rows(exp_rows),
        .frame_valid(frame_valid), .row_valid(row_valid), .expose(expose),
        .pix_stb(pix_stb), .pix_data(pix_data)
    );

    typedef struct packed {
        logic [15:0] t;
        logic        fv;
        logic        rv;
        logic        ex;
        logic [9:0]  d;
    } vec_t;

    // exposure 2, row length 11, frame length 2 + 3*11 = 35
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{16'd0,  1'b1, 1'b0, 1'b0, 10'd0},
        '{16'd1,  1'b1, 1'b0, 1'b0, 10'd0},
        '{16'd2,  1'b1, 1'b0, 1'b1, 10'd0},
        '{16'd3,  1'b1, 1'b1, 1'b1, 10'd0},
        '{16'd8,  1'b1, 1'b1, 1'b1, 10'd5},
        '{16'd9,  1'b1, 1'b0, 1'b1, 10'd0},
        '{16'd13, 1'b1, 1'b0, 1'b1, 10'd0},
        '{16'd14, 1'b1, 1'b1, 1'b1, 10'd32},
        '{16'd19, 1'b1, 1'b1, 1'b1, 10'd37},
        '{16'd24, 1'b1, 1'b0, 1'b0, 10'd0},
        '{16'd25, 1'b1, 1'b1, 1'b0, 10'd64},
        '{16'd30, 1'b1, 1'b1, 1'b0, 10'd69},
        '{16'd31, 1'b0, 1'b0, 1'b0, 10'd0},
        '{16'd34, 1'b0, 1'b0, 1'b0, 10'd0},
        '{16'd35, 1'b1, 1'b0, 1'b0, 10'd0},
        '{16'd38, 1'b1, 1'b1, 1'b1, 10'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic fv, input logic rv,
                           input logic ex, input int d);
        chk(req, "frame_valid", int'(frame_valid), int'(fv));
        chk(req, "row_valid", int'(row_valid), int'(rv));
        chk(req, "expose", int'(expose), int'(ex));
        chk(req, "pix_stb", int'(pix_stb), int'(rv));
        chk(req, "pix_data", int'(pix_data), d);
    endtask

    task automatic go_to(input int t);
        repeat (t - tnow) @(posedge clk);
        tnow = t;
        @(negedge clk);
    endtask

    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        tnow = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        exp_rows = 12'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1 in reset", 1'b0, 1'b0, 1'b0, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_all("R1 idle before start", 1'b0, 1'b0, 1'b0, 0);

        // R2 R3 R4 R6 R8: table walk over one frame with exposure 2
        launch();
        for (int i = 0; i < NV; i++) begin
            go_to(int'(VEC[i].t));
            chk_all("R3 R4 R6 R8 table", VEC[i].fv, VEC[i].rv, VEC[i].ex, int'(VEC[i].d));
        end

        // R2: start while running is ignored
        start = 1'b1;
        go_to(39);
        start = 1'b0;
        go_to(49);
        chk_all("R2 start ignored", 1'b1, 1'b1, 1'b1, 32);

        // R7: change mid-frame has no effect on this frame
        exp_rows = 12'd5;
        go_to(59);
        chk_all("R7 old exposure kept", 1'b1, 1'b0, 1'b0, 0);
        go_to(69);
        chk_all("R7 frame not stretched", 1'b0, 1'b0, 1'b0, 0);
        go_to(70);
        chk_all("R4 next frame on time", 1'b1, 1'b0, 1'b0, 0);

        // R5: exposure 5 stretches frame to 2 + 5*11 = 57
        go_to(101);
        chk_all("R5 after last row", 1'b0, 1'b0, 1'b1, 0);
        exp_rows = 12'd0;
        go_to(105);
        chk_all("R5 no early frame", 1'b0, 1'b0, 1'b1, 0);
        go_to(116);
        chk_all("R6 expose in slot 4", 1'b0, 1'b0, 1'b1, 0);
        go_to(126);
        chk_all("R5 last stretched cycle", 1'b0, 1'b0, 1'b1, 0);
        go_to(127);
        chk_all("R5 stretched period", 1'b1, 1'b0, 1'b0, 0);

        // R6: exposure 0 never raises expose
        go_to(129);
        chk_all("R6 zero exposure", 1'b1, 1'b0, 1'b0, 0);
        go_to(130);
        chk_all("R8 first pixel", 1'b1, 1'b1, 1'b0, 0);
        go_to(162);
        chk_all("R4 period with zero exposure", 1'b1, 1'b0, 1'b0, 0);

        // R1: reset in the middle of a row
        go_to(165);
        rst_n = 1'b0;
        #1;
        chk_all("R1 async reset", 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_all("R1 stays idle", 1'b0, 1'b0, 1'b0, 0);

        // R2 R3: relaunch with exposure equal to ROWS
        exp_rows = 12'd3;
        launch();
        go_to(0);
        chk_all("R2 relaunch", 1'b1, 1'b0, 1'b0, 0);
        go_to(2);
        chk_all("R3 delay cycle", 1'b1, 1'b0, 1'b1, 0);
        go_to(3);
        chk_all("R3 row rise", 1'b1, 1'b1, 1'b1, 0);
        go_to(24);
        chk_all("R6 third slot", 1'b1, 1'b0, 1'b1, 0);
        go_to(35);
        chk_all("R4 equal exposure period", 1'b1, 1'b0, 1'b0, 0);

        summary();
    end
endmodule